// File: doc/BRIEF.md
# Rewind Interrupt Pending Arbiter

This block sits beside a multi-drive tape controller and decides which interrupt source is reported when software acknowledges a shared interrupt. It keeps one pending bit per drive. A drive's bit is set when that drive finishes a rewind that was issued as the rewind-with-interrupt command. A single controller interrupt slot, which remembers the unit that raised it, is merged with these bits. One interrupt-pending line is driven while anything is pending.

An acknowledge pulse produces a registered response one cycle later. The controller interrupt is served first, and its unit number is returned. Otherwise the lowest-numbered pending drive is served: its bit is cleared and its unit number is returned with a device-interrupt flag at bit 6. The response also carries the error bits of the served unit's status byte, masked down to the four error flags.

Every rewind completion also sets a begin-of-tape flag for that drive. A halt addressed to a unit has three effects: it drops that unit's pending bit, it emits a one-cycle cancel strobe for the unit's rewind timer, and it clears the controller interrupt if that interrupt belongs to the same unit.

Top module: `rwi_arbiter`

## Requirements
- R1: A rewind completion (`rw_done` high) sets the begin-of-tape flag of `rw_unit` in `bot_flags` at the next clock edge, whatever the command code; the flag stays set until reset.
- R2: A rewind completion sets the drive's bit in `pend_mask` only when `rw_cmd` equals 8'h13 (rewind with interrupt); any other code, for example 8'h33, leaves `pend_mask` unchanged.
- R3: `irq_pending` is registered and, one cycle after each edge, is high exactly when the controller slot is pending or any `pend_mask` bit is set; it stays high after an acknowledge that leaves rewind bits behind.
- R4: An acknowledge while the controller slot is pending clears the slot, leaves `pend_mask` untouched, and returns `ack_code` equal to the slot's unit number with bit 6 low.
- R5: An acknowledge with no controller interrupt and a nonzero `pend_mask` clears the lowest-numbered set bit and returns `ack_code` = unit number OR 8'h40.
- R6: An acknowledge with nothing pending returns `ack_code` = 0 and changes no state.
- R7: `halt` clears the `halt_unit` bit of `pend_mask`, pulses bit `halt_unit` of `rw_cancel` for exactly the next cycle, and clears the controller slot if its unit equals `halt_unit`.
- R8: `ack_status` is the status byte of the served unit (unit 0 when nothing is pending), taken from `dev_status[8*u +: 8]` and ANDed with 8'hB8, which keeps overrun 0x80, write-lock 0x20, end-of-file 0x10 and data error 0x08.
- R9: When the same cycle both sets and clears a pending bit or the controller slot, the set wins: the bit or slot is pending afterwards, and a new controller request loads its unit.
- R10: Synchronous reset clears `pend_mask`, `bot_flags`, the controller slot, `irq_pending`, `ack_valid`, `ack_code`, `ack_status` and `rw_cancel`.
- R11: `ack_valid` is high for exactly the cycle after an `ack` pulse, and `ack_code`/`ack_status` hold their last values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rw_done | input | 1 | Rewind-complete pulse |
| rw_unit | input | 3 | Drive that finished rewinding |
| rw_cmd | input | 8 | Command code of the finished rewind |
| ctl_req | input | 1 | Controller interrupt request pulse |
| ctl_unit | input | 3 | Unit owning the controller interrupt |
| ack | input | 1 | Interrupt acknowledge pulse |
| halt | input | 1 | Halt pulse for one unit |
| halt_unit | input | 3 | Unit addressed by the halt |
| dev_status | input | 64 | Status byte of every drive, unit u at bits 8u+7..8u |
| irq_pending | output | 1 | Shared interrupt-pending line |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_code | output | 8 | Served unit number, bit 6 set for a drive rewind source |
| ack_status | output | 8 | Masked error bits of the served unit |
| pend_mask | output | 8 | Per-drive rewind interrupt pending bits |
| bot_flags | output | 8 | Per-drive begin-of-tape flags |
| rw_cancel | output | 8 | One-cycle cancel strobe per drive rewind timer |

## Verification
The sweep loads each of the 256 pending patterns and then drains it one acknowledge at a time. A priority picker that favoured the highest bit, or that skipped one, returns units out of order. A design that dropped the line after the first clear shows `irq_pending` low while bits remain. Controller-first ordering is checked with both sources pending together; swapping the order returns a flagged drive code where the bare controller unit is expected. The set-versus-clear collisions (a completion during the acknowledge or halt of the same unit, and a controller request during its own acknowledge) catch a clear-wins implementation, which would lose an interrupt. Completions with a plain rewind code catch a design that ignores the command type.

// File: rtl/rwi_arb_pkg.sv
package rwi_arb_pkg;
  localparam int CMD_W        = 8;
  localparam int STAT_W       = 8;
  localparam int CODE_W       = 8;
  localparam int DEV_FLAG_BIT = 6;
  localparam logic [CMD_W-1:0]  CMD_REWIND_IRQ = 8'h13;
  localparam logic [STAT_W-1:0] ERR_KEEP_MASK  = 8'hB8;
endpackage

// File: rtl/rwi_low_pick.sv
module rwi_low_pick #(
  parameter int N_UNITS = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_UNITS-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [N_UNITS-1:0] onehot
);
  // walk upward from unit 0; the first request seen is the winner
  always_comb begin
    logic found;
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (req[i] && !found) begin
        onehot[i] = 1'b1;
        idx       = IDX_W'(i);
      end
      found = found | req[i];
    end
    any = found;
  end
endmodule

// File: rtl/rwi_pend_bits.sv
module rwi_pend_bits #(
  parameter int N_UNITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_UNITS-1:0] set_vec,
  input  logic [N_UNITS-1:0] clr_vec,
  output logic [N_UNITS-1:0] mask_q,
  output logic [N_UNITS-1:0] mask_next
);
  genvar g;
  generate
    for (g = 0; g < N_UNITS; g++) begin : g_bit
      // a set arriving together with a clear keeps the bit
      assign mask_next[g] = set_vec[g] | (mask_q[g] & ~clr_vec[g]);

      always_ff @(posedge clk) begin
        if (rst) mask_q[g] <= 1'b0;
        else     mask_q[g] <= mask_next[g];
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_vec[g] |=> mask_q[g]);                              // R9
      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[g] && !set_vec[g]) |=> !mask_q[g]);            // R7
      AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr_vec[g] && !set_vec[g]) |=> (mask_q[g] == $past(mask_q[g]))); // R2
    end
  endgenerate
endmodule

// File: rtl/rwi_ctl_slot.sv
module rwi_ctl_slot #(
  parameter int N_UNITS = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] req_unit,
  input  logic             ack_take,
  input  logic             halt,
  input  logic [IDX_W-1:0] halt_unit,
  output logic             pend_q,
  output logic             pend_next,
  output logic [IDX_W-1:0] unit_q
);
  logic drop;

  assign drop      = ack_take | (halt && pend_q && (halt_unit == unit_q));
  assign pend_next = req | (pend_q & ~drop);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      unit_q <= '0;
    end else begin
      pend_q <= pend_next;
      if (req) unit_q <= req_unit;
    end
  end

  AST_CTL_REQ_WINS: assert property (@(posedge clk) disable iff (rst)
    req |=> (pend_q && unit_q == $past(req_unit)));               // R9
  AST_CTL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !req) |=> !pend_q);                              // R4
  AST_CTL_HALTED: assert property (@(posedge clk) disable iff (rst)
    (halt && pend_q && halt_unit == unit_q && !req) |=> !pend_q); // R7
endmodule

// File: rtl/rwi_arbiter.sv
module rwi_arbiter
  import rwi_arb_pkg::*;
#(
  parameter int N_UNITS = 8,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rw_done,
  input  logic [IDX_W-1:0]            rw_unit,
  input  logic [CMD_W-1:0]            rw_cmd,
  input  logic                        ctl_req,
  input  logic [IDX_W-1:0]            ctl_unit,
  input  logic                        ack,
  input  logic                        halt,
  input  logic [IDX_W-1:0]            halt_unit,
  input  logic [N_UNITS*STAT_W-1:0]   dev_status,
  output logic                        irq_pending,
  output logic                        ack_valid,
  output logic [CODE_W-1:0]           ack_code,
  output logic [STAT_W-1:0]           ack_status,
  output logic [N_UNITS-1:0]          pend_mask,
  output logic [N_UNITS-1:0]          bot_flags,
  output logic [N_UNITS-1:0]          rw_cancel
);
  logic [N_UNITS-1:0] done_dec, halt_dec, set_vec, clr_vec, mask_next, pick_oh;
  logic [STAT_W-1:0]  stat_arr [N_UNITS];
  logic               pick_any, ctl_pend, ctl_next, ctl_take, is_irq_cmd;
  logic [IDX_W-1:0]   pick_idx, ctl_owner, serve_idx;
  logic [CODE_W-1:0]  code_next;

  assign is_irq_cmd = (rw_cmd == CMD_REWIND_IRQ);

  genvar g;
  generate
    for (g = 0; g < N_UNITS; g++) begin : g_unit
      assign done_dec[g] = rw_done && (rw_unit == IDX_W'(g));
      assign halt_dec[g] = halt && (halt_unit == IDX_W'(g));
      assign stat_arr[g] = dev_status[g*STAT_W +: STAT_W];
    end
  endgenerate

  rwi_low_pick #(.N_UNITS(N_UNITS)) u_pick (
    .req    (pend_mask),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  // controller interrupt is served before any drive bit
  assign ctl_take = ack && ctl_pend;
  assign set_vec  = is_irq_cmd ? done_dec : '0;
  assign clr_vec  = halt_dec | ((ack && !ctl_pend) ? pick_oh : '0);

  rwi_pend_bits #(.N_UNITS(N_UNITS)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .mask_q    (pend_mask),
    .mask_next (mask_next)
  );

  rwi_ctl_slot #(.N_UNITS(N_UNITS)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .req       (ctl_req),
    .req_unit  (ctl_unit),
    .ack_take  (ctl_take),
    .halt      (halt),
    .halt_unit (halt_unit),
    .pend_q    (ctl_pend),
    .pend_next (ctl_next),
    .unit_q    (ctl_owner)
  );

  always_comb begin
    if (ctl_pend) begin
      serve_idx = ctl_owner;
      code_next = CODE_W'(ctl_owner);
    end else if (pick_any) begin
      serve_idx = pick_idx;
      code_next = CODE_W'(pick_idx) | (CODE_W'(1) << DEV_FLAG_BIT);
    end else begin
      serve_idx = '0;
      code_next = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bot_flags   <= '0;
      ack_valid   <= 1'b0;
      ack_code    <= '0;
      ack_status  <= '0;
      rw_cancel   <= '0;
      irq_pending <= 1'b0;
    end else begin
      bot_flags   <= bot_flags | done_dec;
      ack_valid   <= ack;
      rw_cancel   <= halt_dec;
      irq_pending <= ctl_next | (|mask_next);
      if (ack) begin
        ack_code   <= code_next;
        ack_status <= stat_arr[serve_idx] & ERR_KEEP_MASK;
      end
    end
  end

  AST_BOT_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    rw_done |=> bot_flags[$past(rw_unit)]);                               // R1
  AST_PLAIN_REWIND_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rw_done && !is_irq_cmd && !ack && !halt) |=> (pend_mask == $past(pend_mask))); // R2
  AST_LAST_BIT_DROPS_LINE: assert property (@(posedge clk) disable iff (rst)
    (ack && !ctl_pend && $onehot(pend_mask) && !rw_done && !ctl_req) |=> !irq_pending); // R3
  AST_CTL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ack && ctl_pend) |=> (!ack_code[DEV_FLAG_BIT] && pend_mask == $past(pend_mask | set_vec))); // R4
  AST_DRIVE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (ack && !ctl_pend && |pend_mask) |=> ack_code[DEV_FLAG_BIT]);          // R5
  AST_EMPTY_ACK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ack && !ctl_pend && pend_mask == '0) |=> (ack_code == '0));           // R6
  AST_CANCEL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rw_cancel));                                                  // R7
  AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ((ack_status & ~ERR_KEEP_MASK) == '0));                  // R8
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> ack_valid);                                                    // R11
  AST_ACK_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !ack |=> (!ack_valid && $stable(ack_code)));                           // R11
endmodule

// File: tb/rwi_arbiter_test.sv
module rwi_arbiter_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rw_done = 0, ctl_req = 0, ack = 0, halt = 0;
  logic [2:0] rw_unit = 0, ctl_unit = 0, halt_unit = 0;
  logic [7:0] rw_cmd = 0;
  logic [N*8-1:0] dev_status = '0;
  logic irq_pending, ack_valid;
  logic [7:0] ack_code, ack_status, pend_mask, bot_flags, rw_cancel;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  logic [7:0] m_mask, m_bot;
  logic       m_ctl;
  logic [2:0] m_ctlu;
  logic [7:0] m_code, m_stat;

  always #5 clk = ~clk;

  rwi_arbiter #(.N_UNITS(N)) uut (
    .clk(clk), .rst(rst), .rw_done(rw_done), .rw_unit(rw_unit), .rw_cmd(rw_cmd),
    .ctl_req(ctl_req), .ctl_unit(ctl_unit), .ack(ack), .halt(halt),
    .halt_unit(halt_unit), .dev_status(dev_status), .irq_pending(irq_pending),
    .ack_valid(ack_valid), .ack_code(ack_code), .ack_status(ack_status),
    .pend_mask(pend_mask), .bot_flags(bot_flags), .rw_cancel(rw_cancel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_of(input int u);
    return dev_status[u*8 +: 8];
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    m_mask = 0; m_bot = 0; m_ctl = 0; m_ctlu = 0; m_code = 0; m_stat = 0;
    chk(pend_mask == 0, "R10 mask", pend_mask, 0);
    chk(bot_flags == 0, "R10 bot", bot_flags, 0);
    chk(irq_pending == 0, "R10 irq", irq_pending, 0);
    chk(ack_valid == 0 && ack_code == 0 && ack_status == 0, "R10 ack", ack_code, 0);
    chk(rw_cancel == 0, "R10 cancel", rw_cancel, 0);
  endtask

  // one cycle of stimulus, reference update and full output comparison
  task automatic step(input bit dv, input int du, input logic [7:0] dc,
                      input bit cv, input int cu, input bit av,
                      input bit hv, input int hu);
    logic [7:0] clr, set, cancel;
    logic       ctl_drop;
    int         low;
    @(negedge clk);
    rw_done = dv; rw_unit = 3'(du); rw_cmd = dc;
    ctl_req = cv; ctl_unit = 3'(cu); ack = av; halt = hv; halt_unit = 3'(hu);
    low = -1;
    for (int i = N - 1; i >= 0; i--) if (m_mask[i]) low = i;
    clr = 0; ctl_drop = 0;
    if (av) begin
      if (m_ctl) begin
        m_code = {5'd0, m_ctlu}; m_stat = stat_of(m_ctlu) & 8'hB8; ctl_drop = 1;
      end else if (low >= 0) begin
        m_code = 8'h40 | 8'(low); m_stat = stat_of(low) & 8'hB8; clr[low] = 1'b1;
      end else begin
        m_code = 0; m_stat = stat_of(0) & 8'hB8;
      end
    end
    if (hv) begin
      clr[hu] = 1'b1;
      if (m_ctl && m_ctlu == 3'(hu)) ctl_drop = 1;
    end
    set = 0;
    if (dv && dc == 8'h13) set[du] = 1'b1;
    cancel = 0;
    if (hv) cancel[hu] = 1'b1;
    m_mask = (m_mask & ~clr) | set;
    if (dv) m_bot[du] = 1'b1;
    if (cv) begin m_ctl = 1; m_ctlu = 3'(cu); end
    else if (ctl_drop) m_ctl = 0;
    @(posedge clk); #1;
    rw_done = 0; ctl_req = 0; ack = 0; halt = 0;
    chk(pend_mask == m_mask, "R2/R5/R7/R9 mask", pend_mask, m_mask);
    chk(bot_flags == m_bot, "R1 bot", bot_flags, m_bot);
    chk(irq_pending == (m_ctl || m_mask != 0), "R3 irq", irq_pending, m_ctl || m_mask != 0);
    chk(ack_valid == av, "R11 ack_valid", ack_valid, av);
    chk(ack_code == m_code, "R4/R5/R6 code", ack_code, m_code);
    chk(ack_status == m_stat, "R8 status", ack_status, m_stat);
    chk(rw_cancel == cancel, "R7 cancel", rw_cancel, cancel);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int u = 0; u < N; u++) dev_status[u*8 +: 8] = 8'((u * 37) ^ 8'h5F);
    do_reset();

    // sweep all pending patterns, then drain them lowest first (R2 R3 R5 R6)
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int u = 0; u < N; u++)
        if (p[u]) step(1, u, 8'h13, 0, 0, 0, 0, 0);
        else      step(1, u, 8'h33, 0, 0, 0, 0, 0);
      for (int k = 0; k <= $countones(p[7:0]); k++) step(0, 0, 0, 0, 0, 1, 0, 0);
    end

    // controller first, rewind bits keep the line up (R4 R3)
    do_reset();
    step(1, 5, 8'h13, 0, 0, 0, 0, 0);
    step(1, 2, 8'h13, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 6, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk(ack_code == 8'h06, "R4 controller unit", ack_code, 8'h06);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk(ack_code == 8'h42, "R5 lowest drive", ack_code, 8'h42);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk(ack_code == 8'h00, "R6 empty ack", ack_code, 8'h00);

    // halt clears bit, strobes cancel, clears matching controller slot (R7)
    do_reset();
    step(1, 3, 8'h13, 0, 0, 0, 0, 0);
    step(1, 4, 8'h13, 1, 4, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 3);
    step(0, 0, 0, 0, 0, 0, 1, 4);
    chk(irq_pending == 0, "R7 halt empties line", irq_pending, 0);
    step(0, 0, 0, 1, 1, 0, 1, 7);
    chk(irq_pending == 1, "R7 halt of other unit keeps slot", irq_pending, 1);

    // set beats clear in the same cycle (R9)
    do_reset();
    step(1, 2, 8'h13, 0, 0, 0, 0, 0);
    step(1, 2, 8'h13, 0, 0, 1, 0, 0);
    chk(pend_mask == 8'h04, "R9 ack vs set", pend_mask, 8'h04);
    step(1, 2, 8'h13, 0, 0, 0, 1, 2);
    chk(pend_mask == 8'h04, "R9 halt vs set", pend_mask, 8'h04);
    step(0, 0, 0, 1, 3, 0, 0, 0);
    step(0, 0, 0, 1, 5, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk(ack_code == 8'h05, "R9 re-requested controller", ack_code, 8'h05);

    // other status patterns for the masked status word (R8)
    for (int v = 0; v < 16; v++) begin
      for (int u = 0; u < N; u++) dev_status[u*8 +: 8] = 8'(v * 17 + u * 29);
      step(1, v % N, 8'h13, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0);
      idle();
    end

    // reset from a busy state (R10)
    step(1, 1, 8'h13, 1, 2, 0, 0, 0);
    do_reset();
    finish_run();
  end
endmodule